// File: doc/BRIEF.md
# Single-Error-Correct / Double-Error-Detect Word Codec

This block protects a 64-bit data word with 8 check bits. The encode path takes a data word and returns the 8 check bits to be stored beside it. The decode path takes a 72-bit codeword and returns four things: the corrected data, the syndrome, a correctable flag and an uncorrectable flag. When a single bit has flipped, it also reports the position of that bit and whether it was a data bit or a check bit. Both paths are purely combinational, so a memory controller can place them on its write and read paths without adding latency.

The parity-check matrix is a fixed set of odd-weight columns, with one 8-bit syndrome value per data bit. It is not a positional Hamming code. The decode therefore classifies a syndrome by matching it against that exact column set. Because every column has odd weight, any two flipped bits produce a nonzero even-weight syndrome, which can never be mistaken for a single-bit error.

Top module: `secded_codec`

## Requirements
- R1: Check bit j (j = 0..7) is the XOR of every data bit i whose column value has bit j set. The column values for data bits i = 0..63, in hex, are: d0:F4 d1:F1 d2:EC d3:EA d4:E9 d5:E6 d6:E5 d7:E3 d8:DC d9:DA d10:D9 d11:D6 d12:D5 d13:D3 d14:CE d15:CB d16:B5 d17:B0 d18:AD d19:AB d20:A8 d21:A7 d22:A4 d23:A2 d24:9D d25:9B d26:98 d27:97 d28:94 d29:92 d30:8F d31:8A d32:75 d33:70 d34:6D d35:6B d36:68 d37:67 d38:64 d39:62 d40:5E d41:5B d42:58 d43:57 d44:54 d45:52 d46:4F d47:4A d48:34 d49:31 d50:2C d51:2A d52:29 d53:26 d54:25 d55:23 d56:1C d57:1A d58:19 d59:16 d60:15 d61:13 d62:0E d63:0B.
- R2: A codeword with a zero syndrome decodes to its own data bits, with both flags low, error position 0 and the check-bit indicator low.
- R3: A syndrome equal to the column value of data bit i flips data bit i, raises the correctable flag, reports error position i and keeps the check-bit indicator low.
- R4: A syndrome equal to 1 shifted left by j (check bit j) raises the correctable flag, leaves the data unchanged, reports error position 64 + j and raises the check-bit indicator.
- R5: Any other nonzero syndrome, including every two-bit error, raises the uncorrectable flag and passes the received data bits through unmodified, with the correctable flag low, position 0 and the indicator low.
- R6: The syndrome 0x03, produced by flipping check bits 0 and 1, is classed as uncorrectable.
- R7: The correctable and uncorrectable flags are never high together.
- R8: The syndrome output equals the check bits recomputed from the received data XORed with the received check bits. The codeword carries data in bits 63:0 and check bit j in bit 64 + j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| encData | input | 64 | Data word to encode |
| encCheck | output | 8 | Check bits for encData |
| decWord | input | 72 | Received codeword: data in 63:0, check bits in 71:64 |
| decData | output | 64 | Corrected (or passed-through) data |
| decSyndrome | output | 8 | Syndrome of decWord |
| decCorrectable | output | 1 | A single-bit error was found and handled |
| decUncorrectable | output | 1 | A multi-bit error was found |
| errPos | output | 7 | Codeword position of the corrected bit, 0 when none |
| errInCheck | output | 1 | The corrected bit was a check bit |

## Verification
The bench walks a single flipped bit through all 64 data positions and all 8 check positions, on several data patterns. A design with one wrong or swapped column value would then either miscorrect a neighbouring bit or report the flip as uncorrectable. Pairs of flips across data and check bits, including the check-bit pair that gives syndrome 0x03, target a decoder that accidentally matches an even-weight syndrome and silently corrupts a third bit. Walking single data bits through the encoder exposes a check generator whose masks disagree with the column set, and clean codewords confirm that nothing is flagged or altered when the syndrome is zero.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int WORD_W = DATA_W + CHK_W;
  localparam int POS_W  = $clog2(WORD_W);

  typedef struct packed {
    logic             corr;
    logic             uncorr;
    logic             flipData;
    logic             flipCheck;
    logic [POS_W-1:0] pos;
  } decStrobe_t;

  // Column value of each data bit in the parity-check matrix.
  function automatic logic [CHK_W-1:0] dataColumn(input int idx);
    logic [CHK_W-1:0] c;
    case (idx)
      0: c = 8'hF4;   1: c = 8'hF1;   2: c = 8'hEC;   3: c = 8'hEA;
      4: c = 8'hE9;   5: c = 8'hE6;   6: c = 8'hE5;   7: c = 8'hE3;
      8: c = 8'hDC;   9: c = 8'hDA;  10: c = 8'hD9;  11: c = 8'hD6;
     12: c = 8'hD5;  13: c = 8'hD3;  14: c = 8'hCE;  15: c = 8'hCB;
     16: c = 8'hB5;  17: c = 8'hB0;  18: c = 8'hAD;  19: c = 8'hAB;
     20: c = 8'hA8;  21: c = 8'hA7;  22: c = 8'hA4;  23: c = 8'hA2;
     24: c = 8'h9D;  25: c = 8'h9B;  26: c = 8'h98;  27: c = 8'h97;
     28: c = 8'h94;  29: c = 8'h92;  30: c = 8'h8F;  31: c = 8'h8A;
     32: c = 8'h75;  33: c = 8'h70;  34: c = 8'h6D;  35: c = 8'h6B;
     36: c = 8'h68;  37: c = 8'h67;  38: c = 8'h64;  39: c = 8'h62;
     40: c = 8'h5E;  41: c = 8'h5B;  42: c = 8'h58;  43: c = 8'h57;
     44: c = 8'h54;  45: c = 8'h52;  46: c = 8'h4F;  47: c = 8'h4A;
     48: c = 8'h34;  49: c = 8'h31;  50: c = 8'h2C;  51: c = 8'h2A;
     52: c = 8'h29;  53: c = 8'h26;  54: c = 8'h25;  55: c = 8'h23;
     56: c = 8'h1C;  57: c = 8'h1A;  58: c = 8'h19;  59: c = 8'h16;
     60: c = 8'h15;  61: c = 8'h13;  62: c = 8'h0E;  63: c = 8'h0B;
      default: c = '0;
    endcase
    return c;
  endfunction

  // Row mask: the data bits that feed check bit j.
  function automatic logic [DATA_W-1:0] rowMask(input int j);
    logic [DATA_W-1:0] m;
    logic [CHK_W-1:0]  col;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      col  = dataColumn(i);
      m[i] = col[j];
    end
    return m;
  endfunction
endpackage

// File: rtl/secded_checkgen.sv
module secded_checkgen
  import secded_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [DW-1:0] dataIn,
  output logic [CW-1:0] checkOut
);
  for (genvar j = 0; j < CW; j++) begin : g_row
    localparam logic [DW-1:0] MASK = DW'(rowMask(j));
    assign checkOut[j] = ^(dataIn & MASK);
  end
endmodule

// File: rtl/secded_ctrl.sv
module secded_ctrl
  import secded_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W,
  parameter int PW = POS_W
) (
  input  logic [CW-1:0] syndrome,
  output decStrobe_t    strobe
);
  logic [DW-1:0] dataHit;
  logic [CW-1:0] chkHit;

  for (genvar i = 0; i < DW; i++) begin : g_dataMatch
    localparam logic [CW-1:0] COL = CW'(dataColumn(i));
    assign dataHit[i] = (syndrome == COL);
  end

  for (genvar j = 0; j < CW; j++) begin : g_chkMatch
    assign chkHit[j] = (syndrome == CW'(1 << j));
  end

  always_comb begin
    strobe           = '0;
    strobe.flipData  = |dataHit;
    strobe.flipCheck = |chkHit;
    strobe.corr      = strobe.flipData | strobe.flipCheck;
    strobe.uncorr    = (syndrome != '0) && !strobe.corr;
    for (int i = 0; i < DW; i++) begin
      if (dataHit[i]) strobe.pos = PW'(i);
    end
    for (int j = 0; j < CW; j++) begin
      if (chkHit[j]) strobe.pos = PW'(DW + j);
    end
  end
endmodule

// File: rtl/secded_datapath.sv
module secded_datapath
  import secded_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [DW-1:0]    encData,
  output logic [CW-1:0]    encCheck,
  input  logic [DW+CW-1:0] decWord,
  input  decStrobe_t       strobe,
  output logic [DW-1:0]    decData,
  output logic [CW-1:0]    syndrome
);
  logic [DW-1:0] rxData;
  logic [CW-1:0] rxCheck;
  logic [CW-1:0] reCheck;
  logic [DW-1:0] flipMask;

  assign rxData  = decWord[DW-1:0];
  assign rxCheck = decWord[DW+CW-1:DW];

  secded_checkgen #(.DW(DW), .CW(CW)) u_encGen (
    .dataIn  (encData),
    .checkOut(encCheck)
  );

  secded_checkgen #(.DW(DW), .CW(CW)) u_decGen (
    .dataIn  (rxData),
    .checkOut(reCheck)
  );

  assign syndrome = reCheck ^ rxCheck;

  always_comb begin
    flipMask = '0;
    if (strobe.flipData) flipMask[strobe.pos[$clog2(DW)-1:0]] = 1'b1;
    decData = rxData ^ flipMask;

    AST_ZERO_QUIET: assert (syndrome != '0 || (!strobe.corr && !strobe.uncorr))
      else $error("flag raised on zero syndrome"); // R2
    AST_SINGLE_FLIP: assert ($onehot0(flipMask))
      else $error("more than one data bit flipped"); // R3
    AST_CHECK_KEEPS_DATA: assert (!strobe.flipCheck || decData == rxData)
      else $error("data altered on check-bit error"); // R4
    AST_UE_PASSTHRU: assert (!strobe.uncorr || decData == rxData)
      else $error("data altered on uncorrectable error"); // R5
    AST_FLAGS_EXCL: assert (!(strobe.corr && strobe.uncorr))
      else $error("both flags high"); // R7
  end
endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] encData,
  output logic [CHK_W-1:0]  encCheck,
  input  logic [WORD_W-1:0] decWord,
  output logic [DATA_W-1:0] decData,
  output logic [CHK_W-1:0]  decSyndrome,
  output logic              decCorrectable,
  output logic              decUncorrectable,
  output logic [POS_W-1:0]  errPos,
  output logic              errInCheck
);
  decStrobe_t strobe;

  secded_datapath u_dp (
    .encData (encData),
    .encCheck(encCheck),
    .decWord (decWord),
    .strobe  (strobe),
    .decData (decData),
    .syndrome(decSyndrome)
  );

  secded_ctrl u_ctrl (
    .syndrome(decSyndrome),
    .strobe  (strobe)
  );

  assign decCorrectable   = strobe.corr;
  assign decUncorrectable = strobe.uncorr;
  assign errPos           = strobe.pos;
  assign errInCheck       = strobe.flipCheck;
endmodule

// File: tb/sim_secded_codec.sv
module sim_secded_codec;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [63:0] encData;
  logic [7:0]  encCheck;
  logic [71:0] decWord;
  logic [63:0] decData;
  logic [7:0]  decSyndrome;
  logic        decCorrectable;
  logic        decUncorrectable;
  logic [6:0]  errPos;
  logic        errInCheck;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  secded_codec u0 (
    .encData(encData), .encCheck(encCheck), .decWord(decWord),
    .decData(decData), .decSyndrome(decSyndrome),
    .decCorrectable(decCorrectable), .decUncorrectable(decUncorrectable),
    .errPos(errPos), .errInCheck(errInCheck)
  );

  // Column values from R1.
  function automatic logic [7:0] col(input int i);
    logic [7:0] t [64] = '{
      8'hF4,8'hF1,8'hEC,8'hEA,8'hE9,8'hE6,8'hE5,8'hE3,
      8'hDC,8'hDA,8'hD9,8'hD6,8'hD5,8'hD3,8'hCE,8'hCB,
      8'hB5,8'hB0,8'hAD,8'hAB,8'hA8,8'hA7,8'hA4,8'hA2,
      8'h9D,8'h9B,8'h98,8'h97,8'h94,8'h92,8'h8F,8'h8A,
      8'h75,8'h70,8'h6D,8'h6B,8'h68,8'h67,8'h64,8'h62,
      8'h5E,8'h5B,8'h58,8'h57,8'h54,8'h52,8'h4F,8'h4A,
      8'h34,8'h31,8'h2C,8'h2A,8'h29,8'h26,8'h25,8'h23,
      8'h1C,8'h1A,8'h19,8'h16,8'h15,8'h13,8'h0E,8'h0B};
    return t[i];
  endfunction

  function automatic logic [7:0] refCheck(input logic [63:0] d);
    logic [7:0] c = '0;
    for (int i = 0; i < 64; i++) if (d[i]) c ^= col(i);
    return c;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic decodeAndCheck(input string req, input logic [71:0] w,
      input logic [63:0] eData, input logic [7:0] eSyn, input logic eCorr,
      input logic eUe, input logic [6:0] ePos, input logic eIsChk);
    @(posedge clk);
    decWord = w;
    @(negedge clk);
    chk(req, "data", 72'(decData), 72'(eData));
    chk("R8", "syndrome", 72'(decSyndrome), 72'(eSyn));
    chk(req, "correctable", 72'(decCorrectable), 72'(eCorr));
    chk(req, "uncorrectable", 72'(decUncorrectable), 72'(eUe));
    chk(req, "position", 72'(errPos), 72'(ePos));
    chk(req, "inCheck", 72'(errInCheck), 72'(eIsChk));
    chk("R7", "flag exclusivity", 72'(decCorrectable & decUncorrectable), 72'(0));
  endtask

  logic [63:0] pats [5] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
                            64'hA5A5_5A5A_0F0F_F0F0, 64'h0123_4567_89AB_CDEF,
                            64'h8000_0000_0000_0001};

  task automatic testEncode();
    for (int i = 0; i < 64; i++) begin
      @(posedge clk); encData = 64'd1 << i;
      @(negedge clk);
      chk("R1", $sformatf("walk bit %0d", i), 72'(encCheck), 72'(col(i)));
    end
    for (int p = 0; p < 5; p++) begin
      @(posedge clk); encData = pats[p];
      @(negedge clk);
      chk("R1", "pattern", 72'(encCheck), 72'(refCheck(pats[p])));
    end
  endtask

  task automatic testClean();
    for (int p = 0; p < 5; p++)
      decodeAndCheck("R2", {refCheck(pats[p]), pats[p]}, pats[p], 8'h0, 0, 0, 7'd0, 0);
  endtask

  task automatic testDataFlip();
    for (int p = 0; p < 5; p++)
      for (int i = 0; i < 64; i++)
        decodeAndCheck("R3", {refCheck(pats[p]), pats[p] ^ (64'd1 << i)},
                       pats[p], col(i), 1, 0, 7'(i), 0);
  endtask

  task automatic testCheckFlip();
    for (int p = 0; p < 5; p++)
      for (int j = 0; j < 8; j++)
        decodeAndCheck("R4", {refCheck(pats[p]) ^ (8'd1 << j), pats[p]},
                       pats[p], 8'd1 << j, 1, 0, 7'(64 + j), 1);
  endtask

  task automatic testDouble();
    logic [63:0] d;
    logic [63:0] bad;
    logic [7:0]  c;
    for (int p = 0; p < 5; p++) begin
      d = pats[p];
      c = refCheck(d);
      bad = d ^ 64'h3;
      decodeAndCheck("R5", {c, bad}, bad, col(0) ^ col(1), 0, 1, 7'd0, 0);
      bad = d ^ (64'd1 << 62) ^ (64'd1 << 63);
      decodeAndCheck("R5", {c, bad}, bad, col(62) ^ col(63), 0, 1, 7'd0, 0);
      bad = d ^ (64'd1 << 5);
      decodeAndCheck("R5", {c ^ 8'h08, bad}, bad, col(5) ^ 8'h08, 0, 1, 7'd0, 0);
      bad = d ^ (64'd1 << 17) ^ (64'd1 << 40);
      decodeAndCheck("R5", {c, bad}, bad, col(17) ^ col(40), 0, 1, 7'd0, 0);
      decodeAndCheck("R6", {c ^ 8'h03, d}, d, 8'h03, 0, 1, 7'd0, 0);
      decodeAndCheck("R5", {c ^ 8'hC0, d}, d, 8'hC0, 0, 1, 7'd0, 0);
    end
  endtask

  initial begin
    for (int n = 0; n < 100000 && !done; n++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    encData = '0;
    decWord = '0;
    @(negedge clk);
    chk("R1", "idle encode", 72'(encCheck), 72'(0));
    chk("R2", "idle decode flags", 72'({decCorrectable, decUncorrectable}), 72'(0));
    testEncode();
    testClean();
    testDataFlip();
    testCheckFlip();
    testDouble();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule